// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block generates one interrupt per port of a shared two-port memory, so that two agents can pass short messages to each other. The two highest addresses of the memory are set aside as mailboxes. The top address belongs to port 1, and the address just below it belongs to port 0. When one port writes into its peer's mailbox, the peer's interrupt is asserted. When the owning port reads its own mailbox, the interrupt is cleared. The message data is held in the normal memory array, which sits outside this block.

Each port presents its memory access controls to the block: chip enable, write strobe, output enable, semaphore select and address. Each port also presents a busy indication from the contention arbiter. A port that is being held off by busy can neither raise its peer's interrupt nor clear its own. All controls here are active high except the interrupt outputs, which are active low. Each interrupt output is registered and changes on the clock edge that samples the qualifying access.

Top module: `mbx_irq_top`

## Requirements
- R1: After reset, both `p0_irq_n` and `p1_irq_n` are high.
- R2: A port 0 write to address 0x3FFF drives `p1_irq_n` low on the clock edge that samples the write. A write is chip enable = 1, write strobe = 1 and semaphore select = 0.
- R3: A port 1 write to address 0x3FFE drives `p0_irq_n` low on the clock edge that samples the write.
- R4: An owner read clears that port's interrupt (`irq_n` goes high) on the sampling edge. An owner read is port 1 reading 0x3FFF, or port 0 reading 0x3FFE. A read is chip enable = 1, output enable = 1, write strobe = 0 and semaphore select = 0.
- R5: A port that reads its peer's mailbox leaves both interrupts unchanged.
- R6: A mailbox write made while the writing port's busy input is 1 does not set the peer's interrupt.
- R7: An owner read made while that port's busy input is 1 does not clear its interrupt.
- R8: If a set and a clear of the same interrupt occur in the same cycle, the interrupt ends asserted (low).
- R9: An access with semaphore select = 1, or with chip enable = 0, neither sets nor clears any interrupt.
- R10: A write to the writer's own mailbox has no effect on either interrupt. A write to any address below 0x3FFE also has no effect.
- R11: When no qualifying access occurs, both interrupts keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_ce | input | 1 | Port 0 chip enable |
| p0_we | input | 1 | Port 0 write strobe |
| p0_oe | input | 1 | Port 0 output enable |
| p0_sem | input | 1 | Port 0 semaphore select; when 1, the access is not a memory access |
| p0_addr | input | 14 | Port 0 address |
| p0_busy | input | 1 | Port 0 held off by the arbiter |
| p0_irq_n | output | 1 | Port 0 interrupt, active low |
| p1_ce | input | 1 | Port 1 chip enable |
| p1_we | input | 1 | Port 1 write strobe |
| p1_oe | input | 1 | Port 1 output enable |
| p1_sem | input | 1 | Port 1 semaphore select |
| p1_addr | input | 14 | Port 1 address |
| p1_busy | input | 1 | Port 1 held off by the arbiter |
| p1_irq_n | output | 1 | Port 1 interrupt, active low |

## Verification
The hardest case to reach is a set and a clear of the same flag landing in one cycle. This happens when one port writes the mailbox while its owner reads it in the same cycle. The stimulus drives both ports together in a single cycle to create this overlap, and it also drives both ports writing at once. Busy is raised on exactly the cycle of a mailbox access, once for a write and once for an owner read, and in each case the flag must keep its prior value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Per-port events decoded from one port's access
    typedef struct packed {
        logic peer_set;   // qualified write into the peer's mailbox
        logic own_clr;    // qualified read of the own mailbox
    } mbx_evt_t;

    // Registered state of one interrupt flag
    typedef struct packed {
        logic pend;
    } mbx_flag_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter logic [ADDR_W-1:0] OWN_ADDR  = '1,
    parameter logic [ADDR_W-1:0] PEER_ADDR = '1
) (
    input  logic              ce,
    input  logic              we,
    input  logic              oe,
    input  logic              sem,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output mbx_evt_t          evt
);
    logic mem_sel;
    logic wr_acc;
    logic rd_acc;

    always_comb begin
        mem_sel      = ce && !sem;
        wr_acc       = mem_sel && we;
        rd_acc       = mem_sel && oe && !we;
        evt.peer_set = wr_acc && !busy && (addr == PEER_ADDR);
        evt.own_clr  = rd_acc && !busy && (addr == OWN_ADDR);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    mbx_flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) begin
            flag_d.pend = 1'b1;       // set has priority so no message is lost
        end else if (clr) begin
            flag_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign irq_n = !flag_q.pend;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> !irq_n);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> irq_n);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_ce,
    input  logic              p0_we,
    input  logic              p0_oe,
    input  logic              p0_sem,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_busy,
    output logic              p0_irq_n,
    input  logic              p1_ce,
    input  logic              p1_we,
    input  logic              p1_oe,
    input  logic              p1_sem,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_busy,
    output logic              p1_irq_n
);
    localparam int NPORT = 2;
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;

    logic [NPORT-1:0]  ce_v, we_v, oe_v, sem_v, busy_v, irq_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    mbx_evt_t          evt_v  [NPORT];

    assign ce_v   = {p1_ce,   p0_ce};
    assign we_v   = {p1_we,   p0_we};
    assign oe_v   = {p1_oe,   p0_oe};
    assign sem_v  = {p1_sem,  p0_sem};
    assign busy_v = {p1_busy, p0_busy};
    assign addr_v[0] = p0_addr;
    assign addr_v[1] = p1_addr;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (g == 1) ? TOP_ADDR : NEXT_ADDR;
        localparam logic [ADDR_W-1:0] PEER = (g == 1) ? NEXT_ADDR : TOP_ADDR;

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_ADDR (OWN),
            .PEER_ADDR(PEER)
        ) u_dec (
            .ce  (ce_v[g]),
            .we  (we_v[g]),
            .oe  (oe_v[g]),
            .sem (sem_v[g]),
            .addr(addr_v[g]),
            .busy(busy_v[g]),
            .evt (evt_v[g])
        );

        mbx_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (evt_v[NPORT-1-g].peer_set),
            .clr  (evt_v[g].own_clr),
            .irq_n(irq_v[g])
        );
    end

    assign p0_irq_n = irq_v[0];
    assign p1_irq_n = irq_v[1];

    // Port-level checks
    assert_p0_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_ce && p0_we && !p0_sem && !p0_busy && p0_addr == TOP_ADDR) |=> !p1_irq_n);
    assert_p1_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_ce && p1_we && !p1_sem && !p1_busy && p1_addr == NEXT_ADDR) |=> !p0_irq_n);
    assert_busy_blocks_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_busy && p1_irq_n) |=> p1_irq_n);
    assert_busy_blocks_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_busy && !p1_irq_n) |=> !p1_irq_n);
    assert_peer_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_ce && !p0_sem && p0_addr == TOP_ADDR && !p1_ce && !p1_irq_n) |=> !p1_irq_n);
endmodule

// File: tb/mbx_irq_top_bench.sv
module mbx_irq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam logic [AW-1:0] BOX1 = 14'h3FFF;   // port 1 mailbox
    localparam logic [AW-1:0] BOX0 = 14'h3FFE;   // port 0 mailbox
    localparam int WATCHDOG = 5000;

    typedef struct packed {
        logic ce, we, oe, sem, busy;
        logic [AW-1:0] addr;
    } acc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    acc_t a0, a1;
    logic p0_irq_n, p1_irq_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [1:0] pend = 2'b00;    // model: {port1, port0} pending
    logic [1:0] exp_q [$];       // expected {p1_irq_n, p0_irq_n}
    string      req_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_top #(.ADDR_W(AW)) u_mbx_irq_top (
        .clk(clk), .rst_n(rst_n),
        .p0_ce(a0.ce), .p0_we(a0.we), .p0_oe(a0.oe), .p0_sem(a0.sem),
        .p0_addr(a0.addr), .p0_busy(a0.busy), .p0_irq_n(p0_irq_n),
        .p1_ce(a1.ce), .p1_we(a1.we), .p1_oe(a1.oe), .p1_sem(a1.sem),
        .p1_addr(a1.addr), .p1_busy(a1.busy), .p1_irq_n(p1_irq_n)
    );

    function automatic acc_t idle();
        return '{ce:1'b0, we:1'b0, oe:1'b0, sem:1'b0, busy:1'b0, addr:'0};
    endfunction
    function automatic acc_t wr(logic [AW-1:0] ad);
        return '{ce:1'b1, we:1'b1, oe:1'b0, sem:1'b0, busy:1'b0, addr:ad};
    endfunction
    function automatic acc_t rd(logic [AW-1:0] ad);
        return '{ce:1'b1, we:1'b0, oe:1'b1, sem:1'b0, busy:1'b0, addr:ad};
    endfunction

    function automatic logic is_wr(acc_t a, logic [AW-1:0] ad);
        return a.ce && a.we && !a.sem && !a.busy && a.addr == ad;
    endfunction
    function automatic logic is_rd(acc_t a, logic [AW-1:0] ad);
        return a.ce && a.oe && !a.we && !a.sem && !a.busy && a.addr == ad;
    endfunction

    // Driver: apply one cycle, update the model, queue the expectation
    task automatic step(acc_t x0, acc_t x1, string req);
        @(negedge clk);
        a0 = x0;
        a1 = x1;
        @(posedge clk);
        if (is_wr(x1, BOX0))      pend[0] = 1'b1;
        else if (is_rd(x0, BOX0)) pend[0] = 1'b0;
        if (is_wr(x0, BOX1))      pend[1] = 1'b1;
        else if (is_rd(x1, BOX1)) pend[1] = 1'b0;
        exp_q.push_back(~pend);
        req_q.push_back(req);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if ({p1_irq_n, p0_irq_n} !== e) begin
                fails++;
                $display("FAIL %s: irq_n {p1,p0} actual %b expected %b", r,
                         {p1_irq_n, p0_irq_n}, e);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        acc_t t;
        a0 = idle();
        a1 = idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(idle(), idle(), "R1 reset state");
        step(wr(BOX1), idle(), "R2 p0 writes port1 mailbox");
        step(idle(), idle(), "R11 hold");
        step(rd(BOX1), idle(), "R5 p0 reads peer mailbox");
        step(idle(), rd(BOX1), "R4 p1 owner read clears");
        t = wr(BOX0); t.busy = 1'b1;
        step(idle(), t, "R6 busy write does not set");
        step(idle(), wr(BOX0), "R3 p1 writes port0 mailbox");
        step(idle(), rd(BOX0), "R5 p1 reads peer mailbox");
        t = rd(BOX0); t.busy = 1'b1;
        step(t, idle(), "R7 busy owner read keeps flag");
        step(rd(BOX0), idle(), "R4 p0 owner read clears");
        t = wr(BOX1); t.sem = 1'b1;
        step(t, idle(), "R9 semaphore write ignored");
        t = wr(BOX1); t.ce = 1'b0;
        step(t, idle(), "R9 write without chip enable ignored");
        step(wr(BOX0), idle(), "R10 write to own mailbox ignored");
        step(wr(14'h1234), wr(14'h0000), "R10 ordinary writes ignored");
        step(wr(BOX1), rd(BOX1), "R8 set wins over clear");
        t = rd(BOX1); t.sem = 1'b1;
        step(idle(), t, "R9 semaphore read does not clear");
        step(idle(), rd(BOX1), "R4 clear after R8 case");
        step(wr(BOX1), wr(BOX0), "R2 R3 both ports write together");
        step(rd(BOX0), rd(BOX1), "R4 both owners read together");
        step(idle(), idle(), "R11 idle hold");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule